// File: doc/BRIEF.md
# Pulse Period / High-Time Window Monitor

This block supervises a measured digital input while the capture unit beside it is in measure mode. For each new measurement it takes either the input's period or its high time, chosen by a select bit, and checks it against a lower and an upper bound. A value outside the window produces a one-cycle violation pulse. The bounds are unsigned and inclusive.

After every counter reload, window checking is blanked, because the first measurement after a reload can be wrong. Checking comes back once two rising edges of the input have been seen. A separate timeout counter starts at each reload. If no rising edge arrives within the upper-bound number of cycles, it raises the same violation pulse once. The monitor is inert unless it is enabled and the capture mode field holds the measure-mode code.

Top module: `pulse_window_monitor`

## Requirements
- R1: After synchronous reset, `viol` is low and stays low until a qualifying event occurs.
- R2: With `sel_high`=1 the monitor checks `high_val` on `high_vld`. With `sel_high`=0 it checks `prd_val` on `prd_vld`. The value and strobe of the unselected measurement have no effect.
- R3: A checked value below `lo_bound` or above `hi_bound` makes `viol` high for exactly the cycle after the clock edge that sampled the strobe. A value equal to either bound raises nothing.
- R4: The monitor raises nothing unless `mon_en`=1 and `cap_mode`=3'b100. Any other mode also clears the blanking state and the timeout.
- R5: Leaving reset, and after each reload, measurement strobes are ignored until two rising-edge strobes have been seen. A strobe sampled at the same edge as the second rising edge is checked.
- R6: A reload sampled at the same edge as a measurement strobe or a rising-edge strobe takes precedence. That strobe is not checked and does not count toward re-arming.
- R7: The timeout counts from the reload edge. If no rising-edge strobe is sampled at any of the edges 1 to `hi_bound`+2 after the reload edge, `viol` is high for the cycle after edge `hi_bound`+2.
- R8: At most one timeout pulse is raised per reload. A rising-edge strobe before expiry cancels the timeout.
- R9: Clearing `mon_en` resets the blanking state. After re-enabling, two new rising edges are needed before checks resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_en | input | 1 | Monitor enable |
| sel_high | input | 1 | 1: check high time, 0: check period |
| cap_mode | input | 3 | Capture mode; 3'b100 is measure mode |
| prd_val | input | W | Measured period |
| prd_vld | input | 1 | Period measurement valid strobe |
| high_val | input | W | Measured high time |
| high_vld | input | 1 | High-time measurement valid strobe |
| reload | input | 1 | Counter reload pulse |
| rise | input | 1 | Input rising-edge strobe |
| lo_bound | input | W | Lower window bound (inclusive) |
| hi_bound | input | W | Upper window bound (inclusive), also the timeout limit |
| viol | output | 1 | One-cycle violation pulse |

## Verification
A reload can land in the same cycle as a measurement strobe or a rising-edge strobe. The bench provokes this deliberately in both forms.

In the first case it presents an out-of-window value together with the reload. It then requires `viol` to stay low on that cycle and on a following strobe that has no rising edge before it. In the second case it pairs a reload with a rising edge. It then shows that one later edge is not enough to re-arm, while the second later edge, coinciding with a bad value, produces the pulse.

// File: rtl/pwm_mon_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the window monitor.
// Assumes the capture mode field is three bits wide.
package pwm_mon_pkg;
    localparam logic [2:0] CAP_MEASURE = 3'b100;

    typedef enum logic [1:0] {
        ARM_NONE  = 2'd0,
        ARM_ONE   = 2'd1,
        ARM_READY = 2'd2
    } arm_state_t;
endpackage

// File: rtl/pwm_mon_arm.sv
`timescale 1ns/1ps
// Blanking tracker: counts rising edges after a reload or deactivation and
// allows checks once two have been seen. The second edge's own cycle is allowed.
// Assumes reload and rise are single-cycle strobes in the clk domain.
module pwm_mon_arm
    import pwm_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic reload,
    input  logic rise,
    output logic ok_now
);
    arm_state_t st;
    logic       armed;

    // Edge-count state machine; reload and inactivity restart it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ARM_NONE;
        end else if (!active || reload) begin
            st <= ARM_NONE;
        end else if (rise) begin
            unique case (st)
                ARM_NONE:  st <= ARM_ONE;
                ARM_ONE:   st <= ARM_READY;
                default:   st <= ARM_READY;
            endcase
        end
    end

    // Check permission for the current cycle.
    always_comb begin
        armed  = (st == ARM_READY);
        ok_now = active && !reload && (armed || (st == ARM_ONE && rise));
    end

    AST_ARM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(rise)); // R5
    AST_RELOAD_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !armed); // R6
endmodule

// File: rtl/pwm_mon_timeout.sv
`timescale 1ns/1ps
// Timeout watchdog: starts at a reload and stops at the next rising edge.
// Fires once when the elapsed count exceeds the upper bound.
// Assumes hi_bound is held stable while a timeout is pending.
module pwm_mon_timeout #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         reload,
    input  logic         rise,
    input  logic [W-1:0] hi_bound,
    output logic         to_fire
);
    logic         waiting;
    logic [W-1:0] tcnt;

    // Expiry: still waiting, no edge this cycle, count past the bound.
    always_comb to_fire = waiting && !rise && (tcnt > hi_bound);

    // Wait flag and saturating cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= 1'b0;
            tcnt    <= '0;
        end else if (!active) begin
            waiting <= 1'b0;
        end else if (reload) begin
            waiting <= 1'b1;
            tcnt    <= '0;
        end else if (waiting) begin
            if (rise || to_fire)
                waiting <= 1'b0;
            else if (tcnt != '1)
                tcnt <= tcnt + 1'b1;
        end
    end

    AST_ONE_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        to_fire |=> !to_fire); // R8
    AST_WAIT_FROM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(waiting) |-> $past(reload)); // R7
endmodule

// File: rtl/pwm_mon_window.sv
`timescale 1ns/1ps
// Window comparator: selects period or high time and flags an unsigned
// value outside [lo, hi]. Purely combinational.
module pwm_mon_window #(
    parameter int W = 32
) (
    input  logic         sel_high,
    input  logic [W-1:0] prd_val,
    input  logic         prd_vld,
    input  logic [W-1:0] high_val,
    input  logic         high_vld,
    input  logic [W-1:0] lo_bound,
    input  logic [W-1:0] hi_bound,
    output logic         chk_vld,
    output logic         out_of_range
);
    logic [W-1:0] val;

    // Pick the measurement and compare it with both bounds.
    always_comb begin
        val          = sel_high ? high_val : prd_val;
        chk_vld      = sel_high ? high_vld : prd_vld;
        out_of_range = (val < lo_bound) || (val > hi_bound);
    end
endmodule

// File: rtl/pulse_window_monitor.sv
`timescale 1ns/1ps
// Top: period / high-time window monitor with post-reload blanking and a
// missing-edge timeout. Output is a registered one-cycle violation pulse.
// Assumes all strobes are synchronous single-cycle pulses.
module pulse_window_monitor
    import pwm_mon_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mon_en,
    input  logic         sel_high,
    input  logic [2:0]   cap_mode,
    input  logic [W-1:0] prd_val,
    input  logic         prd_vld,
    input  logic [W-1:0] high_val,
    input  logic         high_vld,
    input  logic         reload,
    input  logic         rise,
    input  logic [W-1:0] lo_bound,
    input  logic [W-1:0] hi_bound,
    output logic         viol
);
    logic active, ok_now, chk_vld, out_of_range, to_fire;

    // Monitor runs only when enabled and in measure mode.
    always_comb active = mon_en && (cap_mode == CAP_MEASURE);

    pwm_mon_arm u_arm (
        .clk(clk), .rst_n(rst_n), .active(active),
        .reload(reload), .rise(rise), .ok_now(ok_now)
    );

    pwm_mon_timeout #(.W(W)) u_to (
        .clk(clk), .rst_n(rst_n), .active(active), .reload(reload),
        .rise(rise), .hi_bound(hi_bound), .to_fire(to_fire)
    );

    pwm_mon_window #(.W(W)) u_win (
        .sel_high(sel_high), .prd_val(prd_val), .prd_vld(prd_vld),
        .high_val(high_val), .high_vld(high_vld), .lo_bound(lo_bound),
        .hi_bound(hi_bound), .chk_vld(chk_vld), .out_of_range(out_of_range)
    );

    // Register the merged violation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            viol <= 1'b0;
        else
            viol <= active && ((chk_vld && out_of_range && ok_now) || to_fire);
    end

    AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode != CAP_MEASURE) |=> !viol); // R4
    AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !viol); // R9
endmodule

// File: tb/pulse_window_monitor_tb.sv
`timescale 1ns/1ps
module pulse_window_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mon_en = 1'b0, sel_high = 1'b0;
    logic [2:0]  cap_mode = 3'b000;
    logic [31:0] prd_val = '0, high_val = '0, lo_bound = '0, hi_bound = '0;
    logic        prd_vld = 1'b0, high_vld = 1'b0, reload = 1'b0, rise = 1'b0;
    logic        viol;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    pulse_window_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .sel_high(sel_high),
        .cap_mode(cap_mode), .prd_val(prd_val), .prd_vld(prd_vld),
        .high_val(high_val), .high_vld(high_vld), .reload(reload), .rise(rise),
        .lo_bound(lo_bound), .hi_bound(hi_bound), .viol(viol)
    );

    // {sel, val, lo, hi, expected}
    localparam logic [97:0] VEC [8] = '{
        {1'b0, 32'd50,  32'd10, 32'd100, 1'b0},
        {1'b0, 32'd9,   32'd10, 32'd100, 1'b1},
        {1'b0, 32'd101, 32'd10, 32'd100, 1'b1},
        {1'b0, 32'd10,  32'd10, 32'd100, 1'b0},
        {1'b1, 32'd100, 32'd10, 32'd100, 1'b0},
        {1'b1, 32'd5,   32'd10, 32'd100, 1'b1},
        {1'b1, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFE, 1'b1},
        {1'b1, 32'd0,   32'd0,  32'd0,   1'b0}
    };

    task automatic chk(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: viol=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // One cycle of stimulus; returns at the following falling edge.
    task automatic step(input logic rl, input logic rs, input logic stb,
                        input logic [31:0] v, input logic [31:0] other);
        @(negedge clk);
        reload = rl; rise = rs;
        if (sel_high) begin
            high_val = v; high_vld = stb; prd_val = other; prd_vld = stb;
        end else begin
            prd_val = v; prd_vld = stb; high_val = other; high_vld = stb;
        end
        @(negedge clk);
        reload = 1'b0; rise = 1'b0; prd_vld = 1'b0; high_vld = 1'b0;
    endtask

    task automatic arm();
        step(1'b1, 1'b0, 1'b0, 0, 0);
        step(1'b0, 1'b1, 1'b0, 0, 0);
        step(1'b0, 1'b1, 1'b0, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: viol=%b expected run end", viol);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(viol, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        mon_en = 1'b1; cap_mode = 3'b100; lo_bound = 10; hi_bound = 100;
        step(1'b0, 1'b0, 1'b1, 32'd1, 32'd1);
        chk(viol, 1'b0, "R1/R5 unarmed after reset");
        step(1'b0, 1'b1, 1'b0, 0, 0);
        step(1'b0, 1'b1, 1'b1, 32'd1, 32'd1);
        chk(viol, 1'b1, "R5 armed by 2 edges from reset");

        // Table walk: R2 select and R3 window, armed once.
        arm();
        for (int i = 0; i < 8; i++) begin
            sel_high = VEC[i][97];
            lo_bound = VEC[i][64:33];
            hi_bound = VEC[i][32:1];
            step(1'b0, 1'b0, 1'b1, VEC[i][96:65],
                 VEC[i][0] ? VEC[i][64:33] : 32'hFFFF_FFFF);
            chk(viol, VEC[i][0], $sformatf("R2/R3 vector %0d", i));
        end
        @(negedge clk);
        chk(viol, 1'b0, "R3 pulse one cycle");

        // R5: one edge is not enough; strobe on second edge is checked.
        sel_high = 1'b0; lo_bound = 10; hi_bound = 100;
        step(1'b1, 1'b0, 1'b0, 0, 0);
        step(1'b0, 1'b1, 1'b0, 0, 0);
        step(1'b0, 1'b0, 1'b1, 32'd5, 32'd50);
        chk(viol, 1'b0, "R5 blanked after one edge");
        step(1'b0, 1'b1, 1'b1, 32'd5, 32'd50);
        chk(viol, 1'b1, "R5 checked on second edge");

        // R6: reload with a strobe wins; blanking follows.
        step(1'b1, 1'b0, 1'b1, 32'd5, 32'd50);
        chk(viol, 1'b0, "R6 reload with strobe");
        step(1'b0, 1'b0, 1'b1, 32'd5, 32'd50);
        chk(viol, 1'b0, "R6 blanked after reload");
        // R6: reload with an edge does not count that edge.
        step(1'b1, 1'b1, 1'b0, 0, 0);
        step(1'b0, 1'b1, 1'b0, 0, 0);
        step(1'b0, 1'b0, 1'b1, 32'd200, 32'd50);
        chk(viol, 1'b0, "R6 edge with reload not counted");
        step(1'b0, 1'b1, 1'b1, 32'd200, 32'd50);
        chk(viol, 1'b1, "R6 re-armed on next edge pair");

        // R7/R8: timeout with hi=5, single pulse after edge 7.
        hi_bound = 5; lo_bound = 0;
        step(1'b1, 1'b0, 1'b0, 0, 0);
        for (int m = 1; m <= 10; m++) begin
            @(negedge clk);
            chk(viol, (m == 7), $sformatf("R7/R8 timeout edge %0d", m));
        end
        // R8: rising edge cancels.
        step(1'b1, 1'b0, 1'b0, 0, 0);
        step(1'b0, 1'b0, 1'b0, 0, 0);
        step(1'b0, 1'b1, 1'b0, 0, 0);
        for (int m = 0; m < 10; m++) begin
            @(negedge clk);
            chk(viol, 1'b0, "R8 edge cancels timeout");
        end

        // R4: other mode, neither window nor timeout fires.
        lo_bound = 10; hi_bound = 3;
        cap_mode = 3'b011;
        step(1'b1, 1'b0, 1'b0, 0, 0);
        for (int m = 0; m < 8; m++) begin
            step(1'b0, 1'b1, 1'b1, 32'd1, 32'd1);
            chk(viol, 1'b0, "R4 not measure mode");
        end
        cap_mode = 3'b100; hi_bound = 100;
        step(1'b0, 1'b0, 1'b1, 32'd1, 32'd1);
        chk(viol, 1'b0, "R4 mode change blanks");

        // R9: enable clear resets blanking.
        arm();
        mon_en = 1'b0;
        step(1'b0, 1'b0, 1'b1, 32'd1, 32'd1);
        chk(viol, 1'b0, "R9 disabled quiet");
        mon_en = 1'b1;
        step(1'b0, 1'b0, 1'b1, 32'd1, 32'd1);
        chk(viol, 1'b0, "R9 blanked after re-enable");
        step(1'b0, 1'b1, 1'b0, 0, 0);
        step(1'b0, 1'b1, 1'b1, 32'd1, 32'd1);
        chk(viol, 1'b1, "R9 resumes after two edges");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule